// File: doc/BRIEF.md
# Shared-Pool Output Queue Manager

This block is the cell buffer of a small N-port cell switch. Every admitted cell, whatever its input, is placed in one common cell store. That store is threaded into one linked-list queue per output port, and the unused locations form a free list of their own. A slot lasts N clock cycles. Sub-slot k of every slot belongs to input k and to output k together. In that one cycle the store takes a write for the arriving cell of input k and a read for the head cell of output k. The slot therefore makes 2N memory accesses, matching a store with one write and one read port.

Admission is checked against the state held at the start of the sub-slot. A cell is refused, and its drop flag pulses, when no free location is left or when its destination queue already holds the per-output cap. The cap is set below the total capacity, so one heavily loaded output cannot take the whole store and starve the others. A dequeue in the same sub-slot does not make room for the arriving cell.

Both data sides are valid/ready streams. An input is offered the chance to transfer only in its own sub-slot. A sender must hold its valid and data steady until ready is seen. A transfer always consumes the cell, whether it is stored or dropped. An output offers its head cell for one cycle per slot. If ready is low in that cycle, the cell stays at the head and is offered again in the next slot. The destination field is the binary output index. The default sizes are 4 ports, 32 stored cells, a cap of 12 per output and a 32-bit payload.

Top module: `shared_cell_qmgr`

## Requirements
- R1: After reset, in_ready is one-hot and rotates one position per cycle. It is high for input k in cycle k of every N-cycle slot, and the first cycle after reset is sub-slot 0.
- R2: A stored cell comes out on the output whose index equals its in_dest value (binary, DW bits per input at bit offset k*DW), and its payload is unchanged.
- R3: Each output delivers its cells in the order they were admitted.
- R4: out_valid for output k is high only in sub-slot k, and only when queue k is non-empty at the start of that cycle. An empty queue offers nothing.
- R5: If out_ready for output k is low while it offers a cell, that cell stays queued and is offered again, unchanged, in the next slot.
- R6: An arriving cell whose destination queue already holds CAP cells is dropped. Its drop bit is high in the transfer cycle, and no other input's drop bit is high then.
- R7: While all B locations are occupied, every arriving cell is dropped, even if its destination is below the cap. A dequeue in the same sub-slot does not free room for it.
- R8: Locations freed by dequeue are reused, so after cells leave, the same number of new cells can be admitted.
- R9: An enqueue to queue k and a dequeue from queue k in the same sub-slot both take effect. This holds even when queue k holds a single cell.
- R10: Reset empties every queue and frees every location. Nothing is offered until a cell is admitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N | Per-input cell present |
| in_ready | output | N | Per-input transfer window (own sub-slot) |
| in_data | input | N*W | Per-input payload, input k at bits k*W |
| in_dest | input | N*DW | Per-input destination output index |
| out_valid | output | N | Per-output head cell offered |
| out_ready | input | N | Per-output sink accepts |
| out_data | output | N*W | Per-output payload, output k at bits k*W |
| drop | output | N | Per-input pulse: transferred cell was refused |

## Verification
The case to provoke is sub-slot k doing two things at once: input k enqueues to output k while output k dequeues. The hardest variant is a queue holding exactly one cell, because its tail link and its head are the same location. The bench creates this by sending input 0 to output 0 in successive slots with output 0 ready. It then checks that the head cell leaves, that the new cell arrives intact in the following slot, and that nothing is lost. A second concurrent pair is a release and an allocation on the free list in the same cycle while the store is full. The bench judges this by a drop that must still occur, and an admission that must succeed one slot later.

// File: rtl/sbq_pkg.sv
package sbq_pkg;
  typedef enum logic [1:0] {
    ADM_IDLE = 2'd0,
    ADM_TAKE = 2'd1,
    ADM_FULL = 2'd2,
    ADM_CAP  = 2'd3
  } adm_e;
endpackage

// File: rtl/sbq_slot_seq.sv
module sbq_slot_seq #(
  parameter int N  = 4,
  parameter int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase,
  output logic [N-1:0]  phase_oh
);
  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else if (phase_q == PW'(N - 1)) phase_q <= '0;
    else phase_q <= phase_q + PW'(1);
  end

  assign phase    = phase_q;
  assign phase_oh = N'(1) << phase_q;
endmodule

// File: rtl/sbq_admit.sv
module sbq_admit
  import sbq_pkg::*;
#(
  parameter int N   = 4,
  parameter int B   = 32,
  parameter int CAP = 12,
  parameter int PW  = (N > 1) ? $clog2(N) : 1,
  parameter int CW  = $clog2(CAP + 1),
  parameter int FW  = $clog2(B + 1)
) (
  input  logic                  req,
  input  logic [PW-1:0]         dest,
  input  logic [N-1:0][CW-1:0]  list_cnt,
  input  logic [FW-1:0]         free_cnt,
  output adm_e                  verdict
);
  logic [CW-1:0] dest_cnt;
  assign dest_cnt = list_cnt[dest];

  always_comb begin
    if (!req)                       verdict = ADM_IDLE;
    else if (free_cnt == '0)        verdict = ADM_FULL;
    else if (dest_cnt >= CW'(CAP))  verdict = ADM_CAP;
    else                            verdict = ADM_TAKE;
  end
endmodule

// File: rtl/sbq_cell_ram.sv
module sbq_cell_ram #(
  parameter int W  = 32,
  parameter int B  = 32,
  parameter int AW = $clog2(B)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] store_q [B];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_addr] <= wr_data;
  end

  assign rd_data = store_q[rd_addr];
endmodule

// File: rtl/sbq_list_ctrl.sv
module sbq_list_ctrl #(
  parameter int N   = 4,
  parameter int B   = 32,
  parameter int CAP = 12,
  parameter int PW  = (N > 1) ? $clog2(N) : 1,
  parameter int AW  = $clog2(B),
  parameter int CW  = $clog2(CAP + 1),
  parameter int FW  = $clog2(B + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enq,
  input  logic [PW-1:0]        enq_dest,
  input  logic                 deq,
  input  logic [PW-1:0]        deq_port,
  output logic [AW-1:0]        alloc_addr,
  output logic [AW-1:0]        head_addr,
  output logic [N-1:0][CW-1:0] list_cnt,
  output logic [FW-1:0]        free_cnt
);
  logic [AW-1:0] link_q [B];
  logic [AW-1:0] head_q [N];
  logic [AW-1:0] tail_q [N];
  logic [CW-1:0] cnt_q  [N];
  logic [AW-1:0] fhead_q;
  logic [FW-1:0] fcnt_q;

  logic [AW-1:0] rel_loc;
  logic [AW-1:0] free_next;
  logic          lone_swap;

  assign rel_loc   = head_q[deq_port];
  assign free_next = link_q[fhead_q];
  // Queue holds one cell which leaves while a new one joins: tail link == head.
  assign lone_swap = enq && deq && (enq_dest == deq_port) && (cnt_q[deq_port] == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < B; i++) link_q[i] <= AW'((i + 1) % B);
      for (int k = 0; k < N; k++) begin
        head_q[k] <= '0;
        tail_q[k] <= '0;
        cnt_q[k]  <= '0;
      end
      fhead_q <= '0;
      fcnt_q  <= FW'(B);
    end else begin
      // free list: released location becomes the new free head
      if (deq) begin
        link_q[rel_loc]  <= enq ? free_next : fhead_q;
        fhead_q          <= rel_loc;
        head_q[deq_port] <= link_q[rel_loc];
      end else if (enq) begin
        fhead_q <= free_next;
      end
      // append the allocated location to the destination queue
      if (enq) begin
        if (cnt_q[enq_dest] == '0 || lone_swap) head_q[enq_dest] <= fhead_q;
        else                                     link_q[tail_q[enq_dest]] <= fhead_q;
        tail_q[enq_dest] <= fhead_q;
      end
      for (int k = 0; k < N; k++) begin
        cnt_q[k] <= cnt_q[k]
                  + CW'(enq && (enq_dest == PW'(k)))
                  - CW'(deq && (deq_port == PW'(k)));
      end
      fcnt_q <= fcnt_q - FW'(enq) + FW'(deq);
    end
  end

  assign alloc_addr = fhead_q;
  assign head_addr  = rel_loc;
  assign free_cnt   = fcnt_q;

  for (genvar g = 0; g < N; g++) begin : g_cnt
    assign list_cnt[g] = cnt_q[g];
  end
endmodule

// File: rtl/shared_cell_qmgr.sv
module shared_cell_qmgr
  import sbq_pkg::*;
#(
  parameter int N   = 4,
  parameter int B   = 32,
  parameter int CAP = 12,
  parameter int W   = 32,
  parameter int DW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    in_valid,
  output logic [N-1:0]    in_ready,
  input  logic [N*W-1:0]  in_data,
  input  logic [N*DW-1:0] in_dest,
  output logic [N-1:0]    out_valid,
  input  logic [N-1:0]    out_ready,
  output logic [N*W-1:0]  out_data,
  output logic [N-1:0]    drop
);
  localparam int AW = $clog2(B);
  localparam int CW = $clog2(CAP + 1);
  localparam int FW = $clog2(B + 1);

  logic [DW-1:0]        phase;
  logic [N-1:0]         phase_oh;
  logic [N-1:0][CW-1:0] list_cnt;
  logic [FW-1:0]        free_cnt;
  logic [AW-1:0]        alloc_addr;
  logic [AW-1:0]        head_addr;
  logic [W-1:0]         rd_data;
  logic                 cur_valid;
  logic [DW-1:0]        cur_dest;
  logic [W-1:0]         cur_data;
  adm_e                 verdict;
  logic                 enq;
  logic                 deq;
  logic                 refused;

  sbq_slot_seq #(.N(N), .PW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .phase(phase), .phase_oh(phase_oh)
  );

  assign cur_valid = |(in_valid & phase_oh);
  assign cur_dest  = in_dest[phase*DW +: DW];
  assign cur_data  = in_data[phase*W +: W];

  sbq_admit #(.N(N), .B(B), .CAP(CAP), .PW(DW), .CW(CW), .FW(FW)) u_admit (
    .req(cur_valid), .dest(cur_dest), .list_cnt(list_cnt),
    .free_cnt(free_cnt), .verdict(verdict)
  );

  assign enq     = (verdict == ADM_TAKE);
  assign refused = (verdict == ADM_FULL) || (verdict == ADM_CAP);
  assign deq     = |(out_valid & out_ready);

  sbq_list_ctrl #(.N(N), .B(B), .CAP(CAP), .PW(DW), .AW(AW), .CW(CW), .FW(FW)) u_lists (
    .clk(clk), .rst_n(rst_n),
    .enq(enq), .enq_dest(cur_dest),
    .deq(deq), .deq_port(phase),
    .alloc_addr(alloc_addr), .head_addr(head_addr),
    .list_cnt(list_cnt), .free_cnt(free_cnt)
  );

  sbq_cell_ram #(.W(W), .B(B), .AW(AW)) u_ram (
    .clk(clk), .wr_en(enq), .wr_addr(alloc_addr), .wr_data(cur_data),
    .rd_addr(head_addr), .rd_data(rd_data)
  );

  assign in_ready = phase_oh;
  assign drop     = phase_oh & {N{refused}};

  for (genvar g = 0; g < N; g++) begin : g_out
    assign out_valid[g]         = phase_oh[g] && (list_cnt[g] != '0);
    assign out_data[g*W +: W]   = rd_data;
  end
endmodule

// File: rtl/sbq_checker.sv
module sbq_checker #(
  parameter int N   = 4,
  parameter int B   = 32,
  parameter int CAP = 12,
  parameter int DW  = (N > 1) ? $clog2(N) : 1,
  parameter int CW  = $clog2(CAP + 1),
  parameter int FW  = $clog2(B + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         in_valid,
  input logic [N-1:0]         in_ready,
  input logic [N*DW-1:0]      in_dest,
  input logic [N-1:0]         drop,
  input logic [N-1:0]         out_valid,
  input logic [N-1:0][CW-1:0] list_cnt,
  input logic [FW-1:0]        free_cnt
);
  int total;
  always_comb begin
    total = int'(free_cnt);
    for (int k = 0; k < N; k++) total += int'(list_cnt[k]);
  end

  assert_one_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_ready) == 1);

  assert_window_wraps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready[N-1] |=> in_ready[0]);

  assert_pool_conserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    total == B);

  assert_full_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == '0 && |(in_valid & in_ready)) |-> |drop);

  assert_drop_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    |drop |-> (drop == (in_valid & in_ready)));

  assert_idle_when_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == FW'(B)) |-> (out_valid == '0));

  for (genvar g = 0; g < N; g++) begin : g_cap
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      list_cnt[g] <= CW'(CAP));
    assert_cap_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[g] && in_ready[g] && list_cnt[in_dest[g*DW +: DW]] == CW'(CAP)) |-> drop[g]);
  end
endmodule

bind shared_cell_qmgr sbq_checker #(.N(N), .B(B), .CAP(CAP), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_dest(in_dest), .drop(drop), .out_valid(out_valid),
  .list_cnt(list_cnt), .free_cnt(free_cnt)
);

// File: tb/shared_cell_qmgr_bench.sv
`timescale 1ns/1ps
module shared_cell_qmgr_bench;
  localparam int N = 4, B = 32, CAP = 12, W = 32, DW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    in_valid = '0;
  logic [N-1:0]    in_ready;
  logic [N*W-1:0]  in_data = '0;
  logic [N*DW-1:0] in_dest = '0;
  logic [N-1:0]    out_valid;
  logic [N-1:0]    out_ready = '0;
  logic [N*W-1:0]  out_data;
  logic [N-1:0]    drop;

  int tests = 0, fails = 0, slotno = 0;
  logic [W-1:0] mq [N][64];
  int mh [N], mt [N], mc [N];
  int mtot = 0;

  always #2.5 clk = ~clk;

  shared_cell_qmgr #(.N(N), .B(B), .CAP(CAP), .W(W)) u_shared_cell_qmgr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_dest(in_dest), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .drop(drop)
  );

  // vector: {in_valid mask, out_ready mask, dests 4x2, expected drop mask}
  localparam logic [19:0] VEC [14] = '{
    20'hF0000, 20'hF0000, 20'hF0000, 20'hF000F,
    20'hF0550, 20'hF0550, 20'hF0550, 20'hF0AA0,
    20'hF0AA0, 20'hF0FFF, 20'h0F000, 20'hF0FF8,
    20'h11001, 20'h11000
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < N; k++) begin mh[k] = 0; mt[k] = 0; mc[k] = 0; end
    mtot = 0;
  endtask

  // called at a negedge in sub-slot 0; returns at the negedge of the next sub-slot 0
  task automatic run_slot(input logic [3:0] vm, input logic [3:0] rm,
                          input logic [7:0] dests, output logic [3:0] dm);
    dm = '0;
    for (int p = 0; p < N; p++) begin
      logic [1:0] d;
      logic expd, expv;
      for (int i = 0; i < N; i++) begin
        in_valid[i]          = vm[i] && (i >= p);
        in_dest[i*DW +: DW]  = dests[i*2 +: 2];
        in_data[i*W +: W]    = {8'hA5, 16'(slotno), 8'(i)};
      end
      out_ready = rm;
      #1;
      chk("R1 in_ready window", W'(in_ready), W'(4'b0001 << p));
      d = dests[p*2 +: 2];
      expd = vm[p] && ((mtot == B) || (mc[d] == CAP));
      chk(mtot == B ? "R7 drop when full" : "R6 drop at cap", W'(drop), expd ? W'(4'b0001 << p) : '0);
      dm[p] = drop[p];
      expv = (mc[p] != 0);
      chk("R4 out_valid", W'(out_valid), expv ? W'(4'b0001 << p) : '0);
      if (expv) chk("R2 R3 R5 head payload", out_data[p*W +: W], mq[p][mh[p]]);
      if (expv && rm[p]) begin mh[p] = (mh[p] + 1) % 64; mc[p]--; mtot--; end
      if (vm[p] && !expd) begin
        mq[d][mt[d]] = {8'hA5, 16'(slotno), 8'(p)};
        mt[d] = (mt[d] + 1) % 64; mc[d]++; mtot++;
      end
      @(negedge clk);
    end
    in_valid = '0;
    out_ready = '0;
    slotno++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = '0;
    out_ready = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [3:0] dm;
    model_clear();
    @(negedge clk);
    do_reset();
    #1;
    chk("R10 nothing offered after reset", W'(out_valid), '0);
    chk("R1 first window is input 0", W'(in_ready), 32'h1);
    chk("R10 no drop after reset", W'(drop), '0);
    #0.5;
    @(negedge clk);
    // realign: one cycle passed, step to the next sub-slot 0
    repeat (N - 1) @(negedge clk);

    // table walk: hot port, cap, full store, reuse, same-sub-slot pairs
    foreach (VEC[v]) begin
      run_slot(VEC[v][19:16], VEC[v][15:12], VEC[v][11:4], dm);
      chk("R6 R7 R8 R9 slot drop mask", W'(dm), W'(VEC[v][3:0]));
    end
    // drain everything in FIFO order
    repeat (13) run_slot(4'h0, 4'hF, 8'h00, dm);
    chk("R8 all cells delivered", W'(mtot), '0);

    // R9: lone cell leaves while a new one joins the same queue
    run_slot(4'h1, 4'h0, 8'h00, dm);
    run_slot(4'h1, 4'h1, 8'h00, dm);
    chk("R9 lone swap admitted", W'(dm), '0);
    run_slot(4'h0, 4'h1, 8'h00, dm);
    run_slot(4'h0, 4'h1, 8'h00, dm);
    chk("R9 queue empty after swap", W'(mtot), '0);

    // R2: distinct destinations per input in one slot, held back one slot (R5)
    run_slot(4'hF, 4'h0, 8'h1B, dm);
    run_slot(4'h0, 4'hF, 8'h00, dm);
    chk("R2 crossed destinations drained", W'(mtot), '0);

    // R10: reset while loaded empties every queue
    run_slot(4'hF, 4'h0, 8'hE4, dm);
    run_slot(4'hF, 4'h0, 8'h00, dm);
    do_reset();
    #1;
    chk("R10 queues cleared by reset", W'(out_valid), '0);
    @(negedge clk);
    repeat (N - 1) @(negedge clk);
    run_slot(4'h0, 4'hF, 8'h00, dm);
    repeat (3) run_slot(4'hF, 4'h0, 8'h00, dm);
    run_slot(4'hF, 4'h0, 8'h00, dm);
    chk("R6 R10 cap reached after reset", W'(dm), 32'hF);
    repeat (4) run_slot(4'h0, 4'hF, 8'h00, dm);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule